// File: doc/BRIEF.md
# Real-Time-Clock Host Register Interface

This block is the host-facing register front end of a real-time clock. A host reaches a 128-byte register space through two addresses: the even address loads a 7-bit index, and the odd address reads or writes the byte that the index selects. Most bytes are plain storage. A few have side effects: two control registers, a flag register that clears when it is read, a fixed status byte, and three alarm bytes.

The calendar counter and the periodic divider sit outside this block. They supply the current seconds, minutes and hours bytes, an update-start strobe, an update-end strobe and a periodic tick. At update end the block compares the three alarm bytes against the current time. A byte whose two top bits are both set counts as a wildcard. The block then sets the matching flag bits and raises its interrupt line. The line stays high until the host reads the flag register.

Top module: `rtc_host_regs`

## Requirements
- R1: A write to the even address (host_addr=0) sets the index to bits 6:0 of the written byte. Write and read accesses at the odd address (host_addr=1) reach the byte that the index selects. Indexes other than 1, 3, 5 and 10 to 13 read back the last value written to them.
- R2: A read at the even address returns 0xFF.
- R3: After reset, control A (index 10) reads 0x26, control B (index 11) reads 0x02, the flag register (index 12) reads 0x00, status D (index 13) reads 0x80, and irq is low.
- R4: Host writes to index 12 and index 13 have no effect on either register.
- R5: Bit 7 of control A is the update-in-progress bit. A host write to control A keeps its current value. An update-start strobe sets it when bit 7 of control B is 0. An update-end strobe clears it.
- R6: A write to control B with bit 7 set clears bit 7 of control A and stores bit 4 of control B as 0. While control B bit 7 is set, update-start does not set the update-in-progress bit.
- R7: A read of index 12 returns the flag register. On that edge the register becomes 0x00 and irq falls.
- R8: The alarm bytes are at index 1 (seconds), 3 (minutes) and 5 (hours). An alarm byte matches when its bits 7:6 are both 1, or when it equals the corresponding time input.
- R9: At an update-end strobe with control B bit 5 set and all three alarm bytes matching, the flag register gains bits 0xA0 and irq rises. If any byte mismatches, no alarm flag is set.
- R10: At an update-end strobe with control B bit 4 set, the flag register gains bits 0x90 and irq rises.
- R11: A periodic tick with control B bit 6 set adds 0xC0 to the flag register and raises irq. With bit 6 clear, the tick is ignored.
- R12: If a flag event occurs in the same cycle as a read of index 12, the read returns the old value. After the edge the flag register holds the new bits and irq stays high.
- R13: irq, once high, stays high until the flag register is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid in the cycle host_re is high |
| tm_sec | input | 8 | Current seconds byte |
| tm_min | input | 8 | Current minutes byte |
| tm_hour | input | 8 | Current hours byte |
| upd_start | input | 1 | Update-start strobe from the calendar |
| upd_end | input | 1 | Update-end strobe from the calendar |
| per_tick | input | 1 | Periodic tick from the divider |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag event that lands in exactly the cycle the host reads the flag register. A plain access sequence cannot produce it. The bench holds the read strobe and the update-end strobe high across the same clock edge. It then checks the byte returned in that cycle, the flag register after the edge, and that irq is still high. Alarm matching is driven through chosen time input values so that exact matches, full wildcards, half-set top bits and a single mismatching field each produce a different flag outcome.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned N_ALM  = 3;

    localparam logic [IDX_W-1:0] IX_ALM_SEC = 7'd1;
    localparam logic [IDX_W-1:0] IX_ALM_MIN = 7'd3;
    localparam logic [IDX_W-1:0] IX_ALM_HR  = 7'd5;
    localparam logic [IDX_W-1:0] IX_CTL_A   = 7'd10;
    localparam logic [IDX_W-1:0] IX_CTL_B   = 7'd11;
    localparam logic [IDX_W-1:0] IX_FLAGS   = 7'd12;
    localparam logic [IDX_W-1:0] IX_STAT_D  = 7'd13;

    localparam int unsigned A_UIP = 7;
    localparam int unsigned B_SET = 7;
    localparam int unsigned B_PIE = 6;
    localparam int unsigned B_AIE = 5;
    localparam int unsigned B_UIE = 4;

    localparam logic [BYTE_W-1:0] FLG_PER = 8'hC0;
    localparam logic [BYTE_W-1:0] FLG_ALM = 8'hA0;
    localparam logic [BYTE_W-1:0] FLG_UPD = 8'h90;

    localparam logic [BYTE_W-1:0] RST_A = 8'h26;
    localparam logic [BYTE_W-1:0] RST_B = 8'h02;
    localparam logic [BYTE_W-1:0] RST_C = 8'h00;
    localparam logic [BYTE_W-1:0] VAL_D = 8'h80;

    typedef struct packed {
        logic [IDX_W-1:0]               idx;
        logic [BYTE_W-1:0]              a;
        logic [BYTE_W-1:0]              b;
        logic [BYTE_W-1:0]              c;
        logic [N_ALM-1:0][BYTE_W-1:0]   alm;
        logic                           irq;
    } ctrl_state_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int unsigned N_FIELDS = 3,
    parameter int unsigned W        = 8
) (
    input  logic [N_FIELDS-1:0][W-1:0] alarm,
    input  logic [N_FIELDS-1:0][W-1:0] now,
    output logic                       match
);
    logic [N_FIELDS-1:0] hit;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        always_comb begin
            hit[i] = (&alarm[i][W-1:W-2]) || (alarm[i] == now[i]);
        end
    end

    always_comb begin
        match = &hit;
    end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int unsigned AW = 7,
    parameter int unsigned W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[addr] = wdata;
        end
        rdata = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regif_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic                          bus_re,
    input  logic                          bus_odd,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic                          upd_start,
    input  logic                          upd_end,
    input  logic                          per_tick,
    input  logic                          alarm_hit,
    output logic [IDX_W-1:0]              idx,
    output logic [BYTE_W-1:0]             reg_a,
    output logic [BYTE_W-1:0]             reg_b,
    output logic [BYTE_W-1:0]             reg_c,
    output logic [N_ALM-1:0][BYTE_W-1:0]  alm,
    output logic                          store_we,
    output logic                          irq
);
    ctrl_state_t s_d, s_q;
    logic        wr_odd;
    logic        rd_flags;
    logic        uip;
    logic [BYTE_W-1:0] evt;
    logic        special;

    always_comb begin
        s_d      = s_q;
        wr_odd   = bus_we && bus_odd;
        rd_flags = bus_re && bus_odd && (s_q.idx == IX_FLAGS);

        uip = s_q.a[A_UIP];
        if (upd_start && !s_q.b[B_SET]) uip = 1'b1;
        if (upd_end) uip = 1'b0;

        evt = '0;
        if (per_tick && s_q.b[B_PIE]) evt = evt | FLG_PER;
        if (upd_end && s_q.b[B_AIE] && alarm_hit) evt = evt | FLG_ALM;
        if (upd_end && s_q.b[B_UIE]) evt = evt | FLG_UPD;

        s_d.c   = (rd_flags ? '0 : s_q.c) | evt;
        s_d.irq = (rd_flags ? 1'b0 : s_q.irq) | (evt != '0);

        if (bus_we && !bus_odd) s_d.idx = wdata[IDX_W-1:0];

        s_d.a[A_UIP] = uip;
        special  = 1'b1;
        if (wr_odd) begin
            unique case (s_q.idx)
                IX_ALM_SEC: s_d.alm[0] = wdata;
                IX_ALM_MIN: s_d.alm[1] = wdata;
                IX_ALM_HR:  s_d.alm[2] = wdata;
                IX_CTL_A:   s_d.a = {uip, wdata[BYTE_W-2:0]};
                IX_CTL_B: begin
                    if (wdata[B_SET]) begin
                        s_d.b        = wdata;
                        s_d.b[B_UIE] = 1'b0;
                        s_d.a[A_UIP] = 1'b0;
                    end else begin
                        s_d.b = wdata;
                    end
                end
                IX_FLAGS, IX_STAT_D: ;
                default: special = 1'b0;
            endcase
        end
        store_we = wr_odd && !special;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.idx <= '0;
            s_q.a   <= RST_A;
            s_q.b   <= RST_B;
            s_q.c   <= RST_C;
            s_q.alm <= '0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        idx   = s_q.idx;
        reg_a = s_q.a;
        reg_b = s_q.b;
        reg_c = s_q.c;
        alm   = s_q.alm;
        irq   = s_q.irq;
    end

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_odd && idx == IX_FLAGS && !upd_end && !per_tick)
        |=> (reg_c == '0 && !irq));

    assert_set_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_odd && idx == IX_CTL_B && wdata[B_SET])
        |=> (!reg_b[B_UIE] && !reg_a[A_UIP]));

    assert_uip_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_odd && idx == IX_CTL_A && !upd_start && !upd_end)
        |=> (reg_a[A_UIP] == $past(reg_a[A_UIP])));

    assert_upd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_end && reg_b[B_UIE]) |=> (reg_c[7] && reg_c[4] && irq));

    assert_irq_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_re && bus_odd && idx == IX_FLAGS)) |=> irq);

    assert_race_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_odd && idx == IX_FLAGS && upd_end && reg_b[B_UIE])
        |=> irq);
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_re,
    input  logic        host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [7:0]  tm_sec,
    input  logic [7:0]  tm_min,
    input  logic [7:0]  tm_hour,
    input  logic        upd_start,
    input  logic        upd_end,
    input  logic        per_tick,
    output logic        irq
);
    logic [IDX_W-1:0]             idx;
    logic [BYTE_W-1:0]            reg_a, reg_b, reg_c, store_rdata;
    logic [N_ALM-1:0][BYTE_W-1:0] alm;
    logic [N_ALM-1:0][BYTE_W-1:0] now;
    logic                         alarm_hit;
    logic                         store_we;

    always_comb begin
        now = {tm_hour, tm_min, tm_sec};
    end

    rtc_alarm_cmp #(.N_FIELDS(N_ALM), .W(BYTE_W)) u_alarm (
        .alarm (alm),
        .now   (now),
        .match (alarm_hit)
    );

    rtc_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (host_we),
        .bus_re    (host_re),
        .bus_odd   (host_addr),
        .wdata     (host_wdata),
        .upd_start (upd_start),
        .upd_end   (upd_end),
        .per_tick  (per_tick),
        .alarm_hit (alarm_hit),
        .idx       (idx),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .reg_c     (reg_c),
        .alm       (alm),
        .store_we  (store_we),
        .irq       (irq)
    );

    rtc_byte_store #(.AW(IDX_W), .W(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .addr  (idx),
        .wdata (host_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        if (!host_addr) begin
            host_rdata = 8'hFF;
        end else begin
            unique case (idx)
                IX_ALM_SEC: host_rdata = alm[0];
                IX_ALM_MIN: host_rdata = alm[1];
                IX_ALM_HR:  host_rdata = alm[2];
                IX_CTL_A:   host_rdata = reg_a;
                IX_CTL_B:   host_rdata = reg_b;
                IX_FLAGS:   host_rdata = reg_c;
                IX_STAT_D:  host_rdata = VAL_D;
                default:    host_rdata = store_rdata;
            endcase
        end
    end

    assert_index_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_addr) |-> (host_rdata == 8'hFF));

    assert_alarm_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_end && reg_b[B_AIE] && alarm_hit) |=> (reg_c[7] && reg_c[5] && irq));
endmodule

// File: tb/rtc_host_regs_test.sv
module rtc_host_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0, host_re = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
    logic       upd_start = 1'b0, upd_end = 1'b0, per_tick = 1'b0;
    logic       irq;
    int         errors = 0;
    int         checks = 0;

    always #2 clk = ~clk;

    rtc_host_regs uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .upd_start(upd_start), .upd_end(upd_end), .per_tick(per_tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_re = 1'b1;
        #1 d = host_rdata;
        @(negedge clk); host_re = 1'b0;
    endtask

    task automatic put_reg(input logic [6:0] ix, input logic [7:0] d);
        bus_write(1'b0, {1'b0, ix});
        bus_write(1'b1, d);
    endtask

    task automatic get_reg(input logic [6:0] ix, output logic [7:0] d);
        bus_write(1'b0, {1'b0, ix});
        bus_read(1'b1, d);
    endtask

    task automatic pulse_end();
        @(negedge clk); upd_end = 1'b1;
        @(negedge clk); upd_end = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); upd_start = 1'b1;
        @(negedge clk); upd_start = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        chk("R3 irq", {7'd0, irq}, 8'h00);
        get_reg(7'd10, v); chk("R3 A", v, 8'h26);
        get_reg(7'd11, v); chk("R3 B", v, 8'h02);
        get_reg(7'd12, v); chk("R3 C", v, 8'h00);
        get_reg(7'd13, v); chk("R3 D", v, 8'h80);
    endtask

    task automatic test_index();
        logic [7:0] v;
        bus_write(1'b0, 8'h8E);
        bus_write(1'b1, 8'h5A);
        put_reg(7'h7F, 8'h3C);
        get_reg(7'h0E, v); chk("R1 byte 0x0E", v, 8'h5A);
        get_reg(7'h7F, v); chk("R1 byte 0x7F", v, 8'h3C);
        bus_read(1'b0, v); chk("R2 index read", v, 8'hFF);
    endtask

    task automatic test_readonly();
        logic [7:0] v;
        put_reg(7'd12, 8'hFF);
        chk("R4 irq after C write", {7'd0, irq}, 8'h00);
        get_reg(7'd12, v); chk("R4 C write ignored", v, 8'h00);
        put_reg(7'd13, 8'h00);
        get_reg(7'd13, v); chk("R4 D write ignored", v, 8'h80);
    endtask

    task automatic test_uip();
        logic [7:0] v;
        pulse_start();
        get_reg(7'd10, v); chk("R5 uip set", v, 8'hA6);
        put_reg(7'd10, 8'h2F);
        get_reg(7'd10, v); chk("R5 write keeps uip", v, 8'hAF);
        pulse_end();
        get_reg(7'd10, v); chk("R5 uip cleared", v, 8'h2F);
        pulse_start();
        put_reg(7'd11, 8'h92);
        get_reg(7'd11, v); chk("R6 uie forced 0", v, 8'h82);
        get_reg(7'd10, v); chk("R6 uip cleared", v, 8'h2F);
        pulse_start();
        get_reg(7'd10, v); chk("R6 no uip under set", v, 8'h2F);
        put_reg(7'd11, 8'h02);
    endtask

    task automatic test_update_flag();
        logic [7:0] v;
        put_reg(7'd11, 8'h12);
        bus_write(1'b0, 8'd12);
        pulse_end();
        chk("R10 irq", {7'd0, irq}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R13 irq held", {7'd0, irq}, 8'h01);
        bus_read(1'b1, v); chk("R7 read value", v, 8'h90);
        chk("R7 irq dropped", {7'd0, irq}, 8'h00);
        bus_read(1'b1, v); chk("R7 cleared", v, 8'h00);
        pulse_end();
        @(negedge clk); host_addr = 1'b1; host_re = 1'b1; upd_end = 1'b1;
        #1 v = host_rdata;
        @(negedge clk); host_re = 1'b0; upd_end = 1'b0;
        chk("R12 read returns old", v, 8'h90);
        chk("R12 irq stays", {7'd0, irq}, 8'h01);
        bus_read(1'b1, v); chk("R12 new flags pending", v, 8'h90);
        put_reg(7'd11, 8'h02);
    endtask

    task automatic test_alarm();
        logic [7:0] v;
        put_reg(7'd1, 8'h30);
        put_reg(7'd3, 8'hC0);
        put_reg(7'd5, 8'h12);
        put_reg(7'd11, 8'h22);
        tm_sec = 8'h30; tm_min = 8'h45; tm_hour = 8'h12;
        bus_write(1'b0, 8'd12);
        pulse_end();
        bus_read(1'b1, v); chk("R9 match", v, 8'hA0);
        tm_sec = 8'h31;
        pulse_end();
        chk("R9 mismatch irq", {7'd0, irq}, 8'h00);
        bus_read(1'b1, v); chk("R9 mismatch", v, 8'h00);
        put_reg(7'd1, 8'hFF);
        put_reg(7'd5, 8'hC5);
        bus_write(1'b0, 8'd12);
        pulse_end();
        bus_read(1'b1, v); chk("R8 all wildcard", v, 8'hA0);
        put_reg(7'd3, 8'h80);
        bus_write(1'b0, 8'd12);
        pulse_end();
        bus_read(1'b1, v); chk("R8 half top bits", v, 8'h00);
        get_reg(7'd3, v); chk("R8 alarm readback", v, 8'h80);
        put_reg(7'd11, 8'h02);
    endtask

    task automatic test_periodic();
        logic [7:0] v;
        put_reg(7'd11, 8'h42);
        bus_write(1'b0, 8'd12);
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
        chk("R11 irq", {7'd0, irq}, 8'h01);
        bus_read(1'b1, v); chk("R11 flags", v, 8'hC0);
        put_reg(7'd11, 8'h02);
        bus_write(1'b0, 8'd12);
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
        chk("R11 gated irq", {7'd0, irq}, 8'h00);
        bus_read(1'b1, v); chk("R11 gated flags", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_index();
        test_readonly();
        test_uip();
        test_update_flag();
        test_alarm();
        test_periodic();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule